// File: doc/BRIEF.md
# GPIO interrupt cause controller

This block is the interrupt front end for a bank of 32 general-purpose input lines. Each line is brought into the clock domain by a two-stage synchronizer, then optionally inverted by a per-bit polarity control. The result, the data-in vector, feeds two interrupt paths. The level path is data-in gated by a level mask. The edge path is a sticky cause register that records rising transitions of data-in, gated by an edge mask.

The masked causes of each block of eight lines are OR-ed into one group interrupt output, giving four outputs. Software acknowledges an edge cause by writing a word whose bit for that line is zero. To catch both edges of a line, software flips that line's polarity after each event. A polarity change never records an edge by itself.

Registers are reached through a simple port: address, write enable, write data and registered read data.

Top module: `gpio_cause_ctrl`

## Requirements
- R1: After a synchronous reset, every register reads zero and all four group interrupt outputs are low.
- R2: The register at address 0x110 returns the synchronized line vector XOR the polarity register at 0x10C, where polarity 1 inverts a line and 0 passes it through. Writes to 0x110 are ignored, and any address other than 0x10C, 0x110, 0x114, 0x118 or 0x11C reads zero.
- R3: A line's level cause is its data-in bit AND its bit in the level mask at 0x11C.
- R4: A 0-to-1 change of a data-in bit sets the matching bit of the edge-cause register at 0x114. That bit stays set until it is cleared.
- R5: A write to 0x114 clears each cause bit whose write-data bit is 0 and leaves each bit whose write-data bit is 1.
- R6: When an edge on a line is detected in the same cycle as a clearing write to its cause bit, the bit ends up set.
- R7: A write to the polarity register that changes data-in does not set any edge-cause bit.
- R8: A line's edge cause is its edge-cause bit AND its bit in the edge mask at 0x118.
- R9: irq_o[g] is the OR of the level and edge causes of lines 8g to 8g+7.
- R10: Read data appears one cycle after the address. irq_o follows data-in and the registers with one register stage, so a line change reaches irq_o two cycles after capture for level causes and three cycles after capture for edge causes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_i | input | 32 | Asynchronous input lines |
| addr_i | input | 12 | Register address |
| we_i | input | 1 | Write enable |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 4 | Group interrupts, one per eight lines |

## Verification
A wrong polarity, mask or cause bit shows at the group output of that line one cycle after it arises, and on rdata_o one cycle after its address is presented. A lost or spurious edge stays visible on the cause read until it is cleared, because the cause is sticky. Mismatches therefore appear within a few cycles of the stimulus that causes them. The directed cases aim at the edge-versus-clear collision and the polarity flip, where a wrong result looks like a correct one unless it is read back.

// File: rtl/gic_pkg.sv
package gic_pkg;
  localparam int unsigned ADDR_W   = 12;
  localparam int unsigned DATA_W   = 32;
  localparam logic [ADDR_W-1:0] OFS_POL  = 12'h10C;
  localparam logic [ADDR_W-1:0] OFS_DIN  = 12'h110;
  localparam logic [ADDR_W-1:0] OFS_ECS  = 12'h114;
  localparam logic [ADDR_W-1:0] OFS_EMSK = 12'h118;
  localparam logic [ADDR_W-1:0] OFS_LMSK = 12'h11C;
endpackage

// File: rtl/gic_sync.sv
module gic_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/gic_edge.sv
module gic_edge #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] raw_i,
  input  logic [W-1:0] pol_i,
  input  logic         clr_we_i,
  input  logic [W-1:0] clr_data_i,
  output logic [W-1:0] din_o,
  output logic [W-1:0] cause_o
);
  logic [W-1:0] raw_prev_q;
  logic [W-1:0] hit;

  // The previous sample is kept raw and re-inverted with the current
  // polarity, so a polarity change alone never looks like a transition.
  assign din_o = raw_i ^ pol_i;
  assign hit   = din_o & ~(raw_prev_q ^ pol_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_prev_q <= '0;
      cause_o    <= '0;
    end else begin
      raw_prev_q <= raw_i;
      cause_o    <= (clr_we_i ? (cause_o & clr_data_i) : cause_o) | hit;
    end
  end

  // R7: only a bit whose synchronized line changed may report a hit
  always_comb begin
    if (!rst) a_r7_no_pol_edge: assert ((hit & ~(raw_i ^ raw_prev_q)) == '0);
  end

  a_r6_edge_wins: assert property (@(posedge clk) disable iff (rst)
    (hit != '0) |=> ((cause_o & $past(hit)) == $past(hit)));

  a_r4_sticky: assert property (@(posedge clk) disable iff (rst)
    !clr_we_i |=> ((cause_o & $past(cause_o)) == $past(cause_o)));

  a_r5_clear: assert property (@(posedge clk) disable iff (rst)
    clr_we_i |=> ((cause_o & ~$past(clr_data_i) & ~$past(hit)) == '0));
endmodule

// File: rtl/gic_group.sv
module gic_group #(
  parameter int unsigned W = 32,
  parameter int unsigned G = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [W-1:0]   src_i,
  output logic [W/G-1:0] irq_o
);
  localparam int unsigned NG = W / G;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    always_ff @(posedge clk) begin
      if (rst) irq_o[g] <= 1'b0;
      else     irq_o[g] <= |src_i[g*G +: G];
    end
  end

  // R9: a group with no active source is low on the next cycle
  a_r9_quiet_group: assert property (@(posedge clk) disable iff (rst)
    (src_i == '0) |=> (irq_o == '0));
endmodule

// File: rtl/gpio_cause_ctrl.sv
module gpio_cause_ctrl
  import gic_pkg::*;
#(
  parameter int unsigned LINES = 32,
  parameter int unsigned GRP   = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [LINES-1:0]    line_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                we_i,
  input  logic [LINES-1:0]    wdata_i,
  output logic [LINES-1:0]    rdata_o,
  output logic [LINES/GRP-1:0] irq_o
);
  localparam int unsigned NGRP = LINES / GRP;

  logic [LINES-1:0] sync_q;
  logic [LINES-1:0] pol_q, lmsk_q, emsk_q;
  logic [LINES-1:0] din, ecause;
  logic [LINES-1:0] rd_next;
  logic             wr_ecs;

  gic_sync #(.W(LINES)) u_sync (
    .clk (clk), .rst (rst), .d_i (line_i), .q_o (sync_q)
  );

  assign wr_ecs = we_i && (addr_i == OFS_ECS);

  gic_edge #(.W(LINES)) u_edge (
    .clk        (clk),
    .rst        (rst),
    .raw_i      (sync_q),
    .pol_i      (pol_q),
    .clr_we_i   (wr_ecs),
    .clr_data_i (wdata_i),
    .din_o      (din),
    .cause_o    (ecause)
  );

  gic_group #(.W(LINES), .G(GRP)) u_grp (
    .clk   (clk),
    .rst   (rst),
    .src_i ((din & lmsk_q) | (ecause & emsk_q)),
    .irq_o (irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pol_q  <= '0;
      lmsk_q <= '0;
      emsk_q <= '0;
    end else if (we_i) begin
      if (addr_i == OFS_POL)  pol_q  <= wdata_i;
      if (addr_i == OFS_LMSK) lmsk_q <= wdata_i;
      if (addr_i == OFS_EMSK) emsk_q <= wdata_i;
    end
  end

  always_comb begin
    case (addr_i)
      OFS_POL:  rd_next = pol_q;
      OFS_DIN:  rd_next = din;
      OFS_ECS:  rd_next = ecause;
      OFS_EMSK: rd_next = emsk_q;
      OFS_LMSK: rd_next = lmsk_q;
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else     rdata_o <= rd_next;
  end

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (irq_o == '0 && rdata_o == '0));

  a_r3_masked_off: assert property (@(posedge clk) disable iff (rst)
    (lmsk_q == '0 && emsk_q == '0) |=> (irq_o == '0));

  a_r2_din_read: assert property (@(posedge clk) disable iff (rst)
    (addr_i == OFS_DIN) |=> (rdata_o == $past(sync_q ^ pol_q)));
endmodule

// File: tb/sim_gpio_cause_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_cause_ctrl;
  localparam logic [11:0] A_POL = 12'h10C, A_DIN = 12'h110, A_ECS = 12'h114,
                          A_EMSK = 12'h118, A_LMSK = 12'h11C;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] line_i = '0;
  logic [11:0] addr_i = '0;
  logic        we_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [3:0]  irq_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit cmp_on  = 1'b0;

  always #2 clk = ~clk;

  gpio_cause_ctrl u0 (
    .clk(clk), .rst(rst), .line_i(line_i), .addr_i(addr_i), .we_i(we_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  // Reference state built from the requirements
  logic [31:0] m_s1, m_s2, m_prev, m_pol, m_lm, m_em, m_ec, m_rd;
  logic [3:0]  m_irq;

  function automatic logic [3:0] grp_or(input logic [31:0] v);
    logic [3:0] r;
    for (int g = 0; g < 4; g++) r[g] = |v[g*8 +: 8];
    return r;
  endfunction

  function automatic logic [31:0] rd_model(input logic [11:0] a, input logic [31:0] din);
    case (a)
      A_POL:  return m_pol;
      A_DIN:  return din;
      A_ECS:  return m_ec;
      A_EMSK: return m_em;
      A_LMSK: return m_lm;
      default: return '0;
    endcase
  endfunction

  always @(posedge clk) begin
    logic [31:0] din, rise, ec_n;
    if (rst) begin
      m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_pol <= '0; m_lm <= '0;
      m_em <= '0; m_ec <= '0; m_rd <= '0; m_irq <= '0;
    end else begin
      din  = m_s2 ^ m_pol;
      rise = din & ~m_prev;
      ec_n = m_ec;
      if (we_i && addr_i == A_ECS) ec_n = ec_n & wdata_i;
      m_ec   <= ec_n | rise;
      m_prev <= m_s2 ^ m_pol;
      m_s1   <= line_i;
      m_s2   <= m_s1;
      if (we_i && addr_i == A_POL) begin
        m_pol  <= wdata_i;
        m_prev <= m_s2 ^ wdata_i;
      end
      if (we_i && addr_i == A_LMSK) m_lm <= wdata_i;
      if (we_i && addr_i == A_EMSK) m_em <= wdata_i;
      m_irq <= grp_or((din & m_lm) | (m_ec & m_em));
      m_rd  <= rd_model(addr_i, din);
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      n_tests++;
      if (irq_o !== m_irq) begin
        n_fail++;
        $display("FAIL R9 irq_o actual=%h expected=%h t=%0t", irq_o, m_irq, $time);
      end
      n_tests++;
      if (rdata_o !== m_rd) begin
        n_fail++;
        $display("FAIL R10 rdata_o addr=%h actual=%h expected=%h t=%0t",
                 addr_i, rdata_o, m_rd, $time);
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk); we_i = 1'b0;
  endtask

  task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); addr_i = a; we_i = 1'b0;
    @(negedge clk);
    n_tests++;
    if (rdata_o !== exp) begin
      n_fail++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, rdata_o, exp);
    end
  endtask

  task automatic irq_chk(input logic [3:0] exp, input string tag);
    n_tests++;
    if (irq_o !== exp) begin
      n_fail++;
      $display("FAIL %s irq_o actual=%h expected=%h", tag, irq_o, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    cmp_on = 1'b1;
    // R1: reset state
    irq_chk(4'h0, "R1");
    rd_chk(A_POL,  32'h0, "R1");
    rd_chk(A_ECS,  32'h0, "R1");
    rd_chk(A_EMSK, 32'h0, "R1");
    rd_chk(A_LMSK, 32'h0, "R1");

    // R3 / R9: level on line 9 reaches group 1 only
    wr(A_LMSK, 32'h0000_0200);
    line_i = 32'h0000_0200;
    idle(4);
    irq_chk(4'h2, "R3");
    // R2: data-in read and polarity inversion; write to data-in ignored
    rd_chk(A_DIN, 32'h0000_0200, "R2");
    wr(A_DIN, 32'hFFFF_FFFF);
    rd_chk(A_DIN, 32'h0000_0200, "R2");
    rd_chk(12'h000, 32'h0, "R2");
    // R4: rising of line 9 latched the cause
    rd_chk(A_ECS, 32'h0000_0200, "R4");
    // R8: edge mask off keeps group quiet after level mask off
    wr(A_LMSK, 32'h0);
    idle(2);
    irq_chk(4'h0, "R8");
    wr(A_EMSK, 32'h0000_0200);
    idle(2);
    irq_chk(4'h2, "R8");
    // R5: clear with inverse word, other bits kept
    wr(A_ECS, 32'hFFFF_FFFF);
    rd_chk(A_ECS, 32'h0000_0200, "R5");
    wr(A_ECS, ~32'h0000_0200);
    rd_chk(A_ECS, 32'h0, "R5");
    idle(2);
    irq_chk(4'h0, "R5");

    // R7: toggling polarity of line 9 (high) makes data-in 0, no cause
    wr(A_POL, 32'h0000_0200);
    idle(3);
    rd_chk(A_DIN, 32'h0, "R7");
    rd_chk(A_ECS, 32'h0, "R7");
    // falling line with inverted polarity is a data-in rise (R4)
    line_i = 32'h0;
    idle(4);
    rd_chk(A_ECS, 32'h0000_0200, "R4");
    // toggling back on a low line: data-in 0, still no new cause (R7)
    wr(A_ECS, 32'h0);
    wr(A_POL, 32'h0);
    idle(3);
    rd_chk(A_ECS, 32'h0, "R7");
    wr(A_POL, 32'h0000_0020);
    idle(3);
    rd_chk(A_DIN, 32'h0000_0020, "R7");
    rd_chk(A_ECS, 32'h0, "R7");
    wr(A_POL, 32'h0);
    idle(3);

    // R6: edge detected in the same cycle as a clearing write
    @(negedge clk); line_i = 32'h0000_0008;
    @(negedge clk);
    @(negedge clk); addr_i = A_ECS; wdata_i = ~32'h0000_0008; we_i = 1'b1;
    @(negedge clk); we_i = 1'b0;
    rd_chk(A_ECS, 32'h0000_0008, "R6");
    wr(A_ECS, 32'h0);

    // R10: level latency, line change to irq_o two cycles after capture
    wr(A_EMSK, 32'h0);
    wr(A_LMSK, 32'h8000_0000);
    @(negedge clk); line_i = 32'h8000_0008;
    @(negedge clk); irq_chk(4'h0, "R10");
    @(negedge clk); irq_chk(4'h0, "R10");
    @(negedge clk); irq_chk(4'h8, "R10");

    // Random phase checked against the reference every cycle
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] sel;
      @(negedge clk);
      line_i = line_i ^ ($urandom & $urandom & $urandom);
      sel = 3'($urandom % 6);
      case (sel)
        3'd0: addr_i = A_POL;
        3'd1: addr_i = A_DIN;
        3'd2: addr_i = A_ECS;
        3'd3: addr_i = A_EMSK;
        3'd4: addr_i = A_LMSK;
        default: addr_i = 12'h0FC;
      endcase
      we_i    = (($urandom % 4) == 0);
      wdata_i = (addr_i == A_ECS) ? ~($urandom & $urandom) : $urandom;
    end
    @(negedge clk); we_i = 1'b0;
    idle(4);
    cmp_on = 1'b0;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule